// File: doc/BRIEF.md
# Range Bar-Graph Video Overlay

This block sits in a pixel pipeline running at the pixel clock and draws a bar graph of distance readings over a horizontal band of the screen. Each visible column has one 8-bit reading in a small sample store. The current horizontal position addresses that store. Inside the band, every pixel becomes pure white or pure black, depending on whether it falls within the bar for its column. Bars rise from the bottom edge of the band. Outside the band, the incoming colour passes through untouched.

The sample store has its own write port, so the acquisition logic can update readings while the overlay is reading them. The video path has two register stages. The first stage lines up the pixel and row with the registered store read. The second stage registers the RGB result. All outputs therefore lag their inputs by exactly two clocks.

Top module: `range_bar_overlay`

## Requirements
- R1: While `rst_n` is low, all colour outputs are zero.
- R2: For a row outside the band, the outputs equal the colour inputs that were presented two clocks earlier.
- R3: The band consists of rows 301 through 364. Rows 300 and 365 are outside it and pass through.
- R4: Only bits 7..2 of a sample set the bar height h (0..63). Bits 1..0 have no effect on the picture.
- R5: Inside the band, a pixel is white exactly when h is nonzero and (row − 300) ≥ (64 − h). Otherwise it is black.
- R6: White drives red = 3'b111, green = 3'b111 and blue = 2'b11. Black drives all three to zero.
- R7: A column whose h is zero has no white pixel anywhere in the band, including row 364.
- R8: A write with `wr_en` high stores `wr_data` at column `wr_addr`. Pixels presented after that clock edge use the new reading.
- R9: A horizontal position of 640 or more reads as h = 0, so in-band pixels at that position are black. A write to such an address changes nothing.
- R10: For a continuous stream of pixels, one per clock, each output pixel uses the reading of its own column, with a fixed latency of two clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcount | input | 10 | Current screen row |
| hcount | input | 10 | Current screen column; also the store read address |
| red_in | input | 3 | Incoming red |
| green_in | input | 3 | Incoming green |
| blue_in | input | 2 | Incoming blue |
| wr_en | input | 1 | Sample write strobe |
| wr_addr | input | 10 | Column whose reading is written |
| wr_data | input | 8 | New distance reading |
| red_out | output | 3 | Outgoing red |
| green_out | output | 3 | Outgoing green |
| blue_out | output | 2 | Outgoing blue |

## Verification
A wrong band flag or misaligned pipeline state appears at the outputs within two clocks. It shows either as passed-through colour on a band row, or as white/black on a row that should pass through. A fault in the stored reading or in the height compare shows up only on in-band rows of the affected column. For that reason, the directed pixels are placed at the exact rows where the bar top sits for chosen heights, and at the top and bottom rows of the band. A one-cycle skew between the store read and the pixel shows as the neighbouring column's bar, so it is caught by streaming columns with different heights back to back.

// File: rtl/rbo_pkg.sv
package rbo_pkg;

  typedef struct packed {
    logic [2:0] r;
    logic [2:0] g;
    logic [1:0] b;
  } rgb_t;

  localparam rgb_t RGB_WHITE = '{r: 3'b111, g: 3'b111, b: 2'b11};
  localparam rgb_t RGB_BLACK = '{r: 3'b000, g: 3'b000, b: 2'b00};

  // Row strictly between the two band limits.
  function automatic logic row_in_band(input int unsigned row,
                                       input int unsigned lo,
                                       input int unsigned hi);
    return (row > lo) && (row < hi);
  endfunction

  // Bar covers the pixel when the offset into the band reaches the
  // window height minus the bar height; an empty bar covers nothing.
  function automatic logic bar_covers(input int unsigned row,
                                      input int unsigned height,
                                      input int unsigned lo,
                                      input int unsigned win);
    return (height != 0) && ((row - lo) >= (win - height));
  endfunction

endpackage

// File: rtl/rbo_sample_store.sv
module rbo_sample_store #(
  parameter int DEPTH = 640,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [DEPTH];
  logic          rd_hit;
  logic          wr_hit;

  assign rd_hit = 32'(raddr) < DEPTH;
  assign wr_hit = we && (32'(waddr) < DEPTH);

  always_ff @(posedge clk) begin
    if (wr_hit) cells[waddr] <= wdata;
  end

  // Registered read; positions past the last column read as an empty bar.
  always_ff @(posedge clk) begin
    rdata <= rd_hit ? cells[raddr] : '0;
  end

endmodule

// File: rtl/rbo_align.sv
module rbo_align
  import rbo_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int BAND_LO = 300,
  parameter int BAND_HI = 365
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row_in,
  input  rgb_t             pix_in,
  output logic             band_s1,
  output logic [ROW_W-1:0] row_s1,
  output rgb_t             pix_s1
);

  logic band_now;

  assign band_now = row_in_band(32'(row_in), BAND_LO, BAND_HI);

  // One stage, matching the store's read latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_s1 <= 1'b0;
      row_s1  <= '0;
      pix_s1  <= RGB_BLACK;
    end else begin
      band_s1 <= band_now;
      row_s1  <= row_in;
      pix_s1  <= pix_in;
    end
  end

endmodule

// File: rtl/rbo_painter.sv
module rbo_painter
  import rbo_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int SAMP_W  = 8,
  parameter int HGT_W   = 6,
  parameter int BAND_LO = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              band_s1,
  input  logic [ROW_W-1:0]  row_s1,
  input  rgb_t              pix_s1,
  input  logic [SAMP_W-1:0] sample_s1,
  output logic [HGT_W-1:0]  height_s1,
  output logic              paint_white,
  output rgb_t              pix_out
);

  localparam int WIN   = 1 << HGT_W;
  localparam int SHIFT = SAMP_W - HGT_W;

  assign height_s1   = HGT_W'(sample_s1 >> SHIFT);
  assign paint_white = band_s1 &&
                       bar_covers(32'(row_s1), 32'(height_s1), BAND_LO, WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pix_out <= RGB_BLACK;
    else if (!band_s1)    pix_out <= pix_s1;
    else if (paint_white) pix_out <= RGB_WHITE;
    else                  pix_out <= RGB_BLACK;
  end

endmodule

// File: rtl/range_bar_overlay.sv
module range_bar_overlay
  import rbo_pkg::*;
#(
  parameter int COLS     = 640,
  parameter int POS_W    = 10,
  parameter int SAMP_W   = 8,
  parameter int BAR_BITS = 6,
  parameter int BAND_LO  = 300,
  parameter int BAND_HI  = 365
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  vcount,
  input  logic [POS_W-1:0]  hcount,
  input  logic [2:0]        red_in,
  input  logic [2:0]        green_in,
  input  logic [1:0]        blue_in,
  input  logic              wr_en,
  input  logic [POS_W-1:0]  wr_addr,
  input  logic [SAMP_W-1:0] wr_data,
  output logic [2:0]        red_out,
  output logic [2:0]        green_out,
  output logic [1:0]        blue_out
);

  rgb_t              pix_in;
  rgb_t              pix_s1;
  rgb_t              pix_out;
  logic              band_s1;
  logic [POS_W-1:0]  row_s1;
  logic [SAMP_W-1:0] sample_s1;
  logic [BAR_BITS-1:0] height_s1;
  logic              paint_white;

  assign pix_in = '{r: red_in, g: green_in, b: blue_in};

  rbo_sample_store #(
    .DEPTH(COLS),
    .AW   (POS_W),
    .DW   (SAMP_W)
  ) u_store (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(hcount),
    .rdata(sample_s1)
  );

  rbo_align #(
    .ROW_W  (POS_W),
    .BAND_LO(BAND_LO),
    .BAND_HI(BAND_HI)
  ) u_align (
    .clk    (clk),
    .rst_n  (rst_n),
    .row_in (vcount),
    .pix_in (pix_in),
    .band_s1(band_s1),
    .row_s1 (row_s1),
    .pix_s1 (pix_s1)
  );

  rbo_painter #(
    .ROW_W  (POS_W),
    .SAMP_W (SAMP_W),
    .HGT_W  (BAR_BITS),
    .BAND_LO(BAND_LO)
  ) u_paint (
    .clk        (clk),
    .rst_n      (rst_n),
    .band_s1    (band_s1),
    .row_s1     (row_s1),
    .pix_s1     (pix_s1),
    .sample_s1  (sample_s1),
    .height_s1  (height_s1),
    .paint_white(paint_white),
    .pix_out    (pix_out)
  );

  assign red_out   = pix_out.r;
  assign green_out = pix_out.g;
  assign blue_out  = pix_out.b;

endmodule

// File: rtl/rbo_checker.sv
module rbo_checker #(
  parameter int POS_W    = 10,
  parameter int BAR_BITS = 6,
  parameter int BAND_LO  = 300,
  parameter int BAND_HI  = 365
) (
  input logic                clk,
  input logic                rst_n,
  input logic [POS_W-1:0]    vcount,
  input logic [2:0]          red_in,
  input logic [2:0]          green_in,
  input logic [1:0]          blue_in,
  input logic [2:0]          red_out,
  input logic [2:0]          green_out,
  input logic [1:0]          blue_out,
  input logic                band_s1,
  input logic [BAR_BITS-1:0] height_s1,
  input logic                paint_white
);

  logic [1:0] age;
  logic [7:0] px_in;
  logic [7:0] px_out;
  logic       row_band;

  assign px_in    = {red_in, green_in, blue_in};
  assign px_out   = {red_out, green_out, blue_out};
  assign row_band = (32'(vcount) > BAND_LO) && (32'(vcount) < BAND_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (px_out == 8'h00);
    end
  end

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !$past(row_band, 2)) |-> (px_out == $past(px_in, 2)));

  // R6
  white_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paint_white |=> (px_out == 8'hFF));

  // R5
  black_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (band_s1 && !paint_white) |=> (px_out == 8'h00));

  // R7
  empty_bar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (height_s1 == '0) |-> !paint_white);

endmodule

bind range_bar_overlay rbo_checker #(
  .POS_W   (POS_W),
  .BAR_BITS(BAR_BITS),
  .BAND_LO (BAND_LO),
  .BAND_HI (BAND_HI)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vcount     (vcount),
  .red_in     (red_in),
  .green_in   (green_in),
  .blue_in    (blue_in),
  .red_out    (red_out),
  .green_out  (green_out),
  .blue_out   (blue_out),
  .band_s1    (band_s1),
  .height_s1  (height_s1),
  .paint_white(paint_white)
);

// File: tb/range_bar_overlay_test.sv
`timescale 1ns/1ps
module range_bar_overlay_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] vcount = '0;
  logic [9:0] hcount = '0;
  logic [2:0] red_in = '0;
  logic [2:0] green_in = '0;
  logic [1:0] blue_in = '0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] red_out;
  logic [2:0] green_out;
  logic [1:0] blue_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model [640];

  always #5 clk = ~clk;

  range_bar_overlay uut (
    .clk(clk), .rst_n(rst_n), .vcount(vcount), .hcount(hcount),
    .red_in(red_in), .green_in(green_in), .blue_in(blue_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .red_out(red_out), .green_out(green_out), .blue_out(blue_out)
  );

  function automatic logic [7:0] expect_px(input int row, input int col,
                                           input logic [7:0] rgb);
    int h;
    if (row <= 300 || row >= 365) return rgb;
    h = (col < 640) ? int'(model[col] / 4) : 0;
    // Lit rows for height h run from 364-h up to 364.
    if (h > 0 && row >= 364 - h) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] got,
                       input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic drive(input int row, input int col, input logic [7:0] rgb);
    vcount   = 10'(row);
    hcount   = 10'(col);
    red_in   = rgb[7:5];
    green_in = rgb[4:2];
    blue_in  = rgb[1:0];
  endtask

  task automatic one_pixel(input string req, input int row, input int col,
                           input logic [7:0] rgb);
    @(negedge clk);
    drive(row, col, rgb);
    @(negedge clk);
    @(negedge clk);
    check(req, {red_out, green_out, blue_out}, expect_px(row, col, rgb));
  endtask

  task automatic put_sample(input int col, input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 10'(col); wr_data = val;
    if (col < 640) model[col] = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    drive(340, 3, 8'h5A);
    repeat (3) @(negedge clk);
    check("R1 reset", {red_out, green_out, blue_out}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_load;
    for (int i = 0; i < 640; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 10'(i); wr_data = 8'((i * 37 + 11) % 256);
      model[i] = 8'((i * 37 + 11) % 256);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_pass;
    one_pixel("R2 row 0", 0, 20, 8'hA5);
    one_pixel("R2 row 100", 100, 200, 8'h3C);
    one_pixel("R2 row 479", 479, 639, 8'hFF);
    one_pixel("R3 row 300", 300, 50, 8'h81);
    one_pixel("R3 row 365", 365, 50, 8'h42);
  endtask

  task automatic t_heights;
    put_sample(5, 8'h04);
    one_pixel("R5 h1 row 364", 364, 5, 8'h12);
    one_pixel("R5 h1 row 363", 363, 5, 8'h12);
    one_pixel("R5 h1 row 362", 362, 5, 8'h12);
    put_sample(6, 8'hFF);
    one_pixel("R6 h63 row 301", 301, 6, 8'h00);
    one_pixel("R3 h63 row 300", 300, 6, 8'h24);
    put_sample(10, 8'h80);
    one_pixel("R5 h32 row 332", 332, 10, 8'h33);
    one_pixel("R5 h32 row 331", 331, 10, 8'h33);
  endtask

  task automatic t_low_bits;
    put_sample(7, 8'h03);
    one_pixel("R7 empty row 364", 364, 7, 8'hEE);
    one_pixel("R4 low bits row 340", 340, 7, 8'hEE);
    put_sample(8, 8'h07);
    one_pixel("R4 low bits h1 row 363", 363, 8, 8'h11);
    one_pixel("R4 low bits h1 row 362", 362, 8, 8'h11);
  endtask

  task automatic t_rewrite;
    put_sample(12, 8'h00);
    one_pixel("R8 before write", 310, 12, 8'h77);
    put_sample(12, 8'hFC);
    one_pixel("R8 after write", 310, 12, 8'h77);
  endtask

  task automatic t_beyond;
    put_sample(700, 8'hFF);
    one_pixel("R9 col 700 row 364", 364, 700, 8'h6D);
    one_pixel("R9 col 639 row 364", 364, 639, 8'h6D);
    one_pixel("R9 col 700 outside band", 200, 700, 8'h6D);
  endtask

  task automatic t_stream;
    int rows [100];
    logic [7:0] pix [100];
    for (int i = 0; i < 102; i++) begin
      @(negedge clk);
      if (i >= 2)
        check("R10 stream", {red_out, green_out, blue_out},
              expect_px(rows[i-2], i - 2, pix[i-2]));
      if (i < 100) begin
        rows[i] = (i % 3 == 0) ? 299 : 330 + (i % 30);
        pix[i]  = 8'(i * 13);
        drive(rows[i], i, pix[i]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load();
    t_pass();
    t_heights();
    t_low_bits();
    t_rewrite();
    t_beyond();
    t_stream();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule